// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between clocked logic and an external asynchronous static RAM of 32768 byte-wide locations. A client hands it one read or one write at a time over a valid/ready handshake. The block then drives the memory's address lines, its three active-low strobes (select, output drive, write) and its shared 8-bit data bus through a fixed series of phases. Each phase lasts a whole number of clock cycles.

Every phase length is computed when the block is elaborated. The block takes the memory's minimum timings in nanoseconds and the clock period, divides one by the other, rounds up and applies a floor of one cycle. The block returns read data with a single-cycle valid pulse. After every access it holds a deselected turnaround window, so that the memory's output drivers and the block's own drivers never overlap on the shared bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and in the cycle after it, the select, output-drive and write strobes are high (1), the block does not drive the data bus, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only when the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. Request inputs presented while `req_ready` is 0 are ignored.
- R3: A read holds the select and output-drive strobes low and the write strobe high for exactly ACC cycles. It starts in the cycle after acceptance and presents the accepted 15-bit address for the whole time select is low.
- R4: Read data is sampled on the last access cycle. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, ACC cycles after the acceptance cycle.
- R5: A write holds select low and output-drive high throughout. The write strobe stays high for WSU setup cycles and then goes low for WP cycles.
- R6: The block drives the write data onto the bus only during the setup and strobe cycles of a write. It never drives the bus while the output-drive strobe is low. It releases the bus on the edge where the write strobe rises.
- R7: Every access ends with TURN cycles in which select is high and the bus is released, before `req_ready` returns to 1. A read is therefore always separated from a following write by a deselected cycle.
- R8: The cycle counts are derived as ceil(ns / CLK_NS) with a floor of 1. ACC comes from the address access time. WSU comes from the address setup time. WP is the largest of the pulse width, the full write cycle minus WSU, and the data setup minus WSU. TURN comes from the output-disable time.
- R9: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Memory address lines |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output drive, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
Cycles are counted from the rising edge that accepts a request, with index 0 as the first cycle after it. The strobes change in cycle 0, `rsp_valid` is due in cycle ACC, the write strobe falls in cycle WSU, and `req_ready` returns in cycle ACC+TURN for a read or WSU+WP+TURN for a write. The bench samples every output on the falling edge. It counts, in each cycle index, how many cycles each strobe is low and when it first falls, and compares those counts with values it computes from the same nanosecond figures. During each busy window the bench keeps a conflicting request on the inputs, so that any leak into the address or into the strobe pattern shows up.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_TURN
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // ceil(ns / clk_ns), never below one cycle
    function automatic int cycles_for(input int ns, input int clk_ns);
        int r;
        r = (ns + clk_ns - 1) / clk_ns;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic strobe_t strobe_for(input phase_e ph);
        strobe_t s;
        s = STROBE_IDLE;
        case (ph)
            ST_READ:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
            ST_WSETUP: begin s.ce_n = 1'b0; s.drive = 1'b1; end
            ST_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
            default:   s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R8: a phase never gets a zero-length load
    assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ACC   = 2,
    parameter int WSU   = 1,
    parameter int WP    = 1,
    parameter int TURN  = 1,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    input  logic             last,
    output logic             load,
    output logic [CNT_W-1:0] len,
    output strobe_t          strobe,
    output logic             capture
);
    localparam logic [CNT_W-1:0] ACC_L  = CNT_W'(ACC);
    localparam logic [CNT_W-1:0] WSU_L  = CNT_W'(WSU);
    localparam logic [CNT_W-1:0] WP_L   = CNT_W'(WP);
    localparam logic [CNT_W-1:0] TURN_L = CNT_W'(TURN);

    phase_e  state_q, state_d;
    strobe_t strobe_q;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        len     = TURN_L;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = req_write ? ST_WSETUP : ST_READ;
                load    = 1'b1;
                len     = req_write ? WSU_L : ACC_L;
            end
            ST_READ: if (last) begin
                state_d = ST_TURN;
                load    = 1'b1;
                len     = TURN_L;
            end
            ST_WSETUP: if (last) begin
                state_d = ST_WPULSE;
                load    = 1'b1;
                len     = WP_L;
            end
            ST_WPULSE: if (last) begin
                state_d = ST_TURN;
                load    = 1'b1;
                len     = TURN_L;
            end
            ST_TURN: if (last) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_q <= STROBE_IDLE;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobe_for(state_d);
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign capture   = (state_q == ST_READ) && last;
    assign strobe    = strobe_q;

    assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_oe_we_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(!strobe_q.oe_n && !strobe_q.we_n));

    assert_turn_deselected_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TURN) |-> (strobe_q.ce_n && !strobe_q.drive));

    assert_we_after_setup_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_q.we_n) |-> ($past(state_q) == ST_WSETUP));

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ce_n,
    input  logic              drive,
    input  logic              capture,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_dq;
        end
    end

    assign mem_dq    = drive ? wdata_q : {DATA_W{1'bz}};
    assign mem_addr  = addr_q;
    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;

    assert_rsp_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |=> !rvalid_q);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_AA_NS  = 12,
    parameter int T_AS_NS  = 0,
    parameter int T_WP_NS  = 9,
    parameter int T_WC_NS  = 12,
    parameter int T_DW_NS  = 8,
    parameter int T_OHZ_NS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int ACC_CYC  = cycles_for(T_AA_NS, CLK_NS);
    localparam int WSU_CYC  = cycles_for(T_AS_NS, CLK_NS);
    localparam int WP_CYC   = max3(cycles_for(T_WP_NS, CLK_NS),
                                   cycles_for(T_WC_NS, CLK_NS) - WSU_CYC,
                                   cycles_for(T_DW_NS, CLK_NS) - WSU_CYC);
    localparam int TURN_CYC = cycles_for(T_OHZ_NS, CLK_NS);
    localparam int MAX_CYC  = max3(max3(ACC_CYC, WSU_CYC, WP_CYC), TURN_CYC, 1);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             load;
    logic [CNT_W-1:0] len;
    logic             last;
    logic             capture;
    strobe_t          strobe;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (len),
        .last (last)
    );

    sram_ctl_fsm #(
        .ACC   (ACC_CYC),
        .WSU   (WSU_CYC),
        .WP    (WP_CYC),
        .TURN  (TURN_CYC),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .last      (last),
        .load      (load),
        .len       (len),
        .strobe    (strobe),
        .capture   (capture)
    );

    sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
        .clk       (clk),
        .rst       (rst),
        .accept    (req_valid && req_ready),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ce_n      (strobe.ce_n),
        .drive     (strobe.drive),
        .capture   (capture),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_ce_n = strobe.ce_n;
    assign mem_oe_n = strobe.oe_n;
    assign mem_we_n = strobe.we_n;

    assert_drive_needs_oe_high_R6: assert property (@(posedge clk) disable iff (rst)
        strobe.drive |-> mem_oe_n);

    assert_read_data_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
    localparam int CLK_NS = 4;

    function automatic int cyc(input int ns);
        int r;
        r = (ns + CLK_NS - 1) / CLK_NS;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_ACC  = cyc(12);
    localparam int E_WSU  = cyc(0);
    localparam int E_WP   = mx(mx(cyc(9), cyc(12) - E_WSU), cyc(8) - E_WSU);
    localparam int E_TURN = cyc(7);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mdl [256] = '{default: 8'h00};
    logic [7:0] exp_mem [256] = '{default: 8'h00};

    always #5 clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_NS)) i_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    // memory model, aliased on the low 8 address bits
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[7:0]] : 8'bz;
    always @(negedge clk) if (!mem_ce_n && !mem_we_n) mdl[mem_addr[7:0]] <= mem_dq;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int ce_lo = 0, oe_lo = 0, we_lo = 0, we_first = -1;
        int rsp_n = 0, rsp_idx = -1, idx = 0, bad_addr = 0, bad_dq = 0;
        logic [7:0] rsp_d = '0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        // conflicting request held during busy window: must be ignored (R2)
        req_write = !wr; req_addr = ~a; req_wdata = ~d;
        while (!req_ready && idx < 64) begin
            if (!mem_ce_n) begin
                ce_lo++;
                if (mem_addr != a) bad_addr++;
            end
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) begin
                we_lo++;
                if (we_first < 0) we_first = idx;
                if (mem_dq != d) bad_dq++;
            end
            if (rsp_valid) begin
                rsp_n++; rsp_idx = idx; rsp_d = rsp_rdata;
            end
            @(negedge clk);
            idx++;
        end
        req_valid = 1'b0;
        chk(bad_addr == 0, "R3 address held while selected", bad_addr, 0);
        if (wr) begin
            exp_mem[a[7:0]] = d;
            chk(oe_lo == 0, "R5 output drive high during write", oe_lo, 0);
            chk(we_first == E_WSU, "R5 R8 strobe falls after setup", we_first, E_WSU);
            chk(we_lo == E_WP, "R5 R8 strobe width", we_lo, E_WP);
            chk(ce_lo == E_WSU + E_WP, "R5 select low for write", ce_lo, E_WSU + E_WP);
            chk(bad_dq == 0, "R6 write data on bus under strobe", bad_dq, 0);
            chk(idx == E_WSU + E_WP + E_TURN, "R7 write turnaround", idx, E_WSU + E_WP + E_TURN);
        end else begin
            chk(we_lo == 0, "R3 write strobe high during read", we_lo, 0);
            chk(oe_lo == E_ACC && ce_lo == E_ACC, "R3 R8 access length", oe_lo, E_ACC);
            chk(rsp_n == 1 && rsp_idx == E_ACC, "R4 response timing", rsp_idx, E_ACC);
            chk(rsp_d == exp_mem[a[7:0]], "R9 read data", int'(rsp_d), int'(exp_mem[a[7:0]]));
            chk(idx == E_ACC + E_TURN, "R7 read turnaround", idx, E_ACC + E_TURN);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
            int'({req_ready, rsp_valid}), 2);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high after reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);

        // directed corners
        do_op(1'b1, 15'h0000, 8'hA5);
        do_op(1'b1, 15'h7FFF, 8'h5A);
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b1, 15'h7FFF, 8'hFF);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b1, 15'h1234, 8'h00);
        do_op(1'b0, 15'h1234, 8'h00);

        // random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 80; n++) begin
            logic [14:0] a;
            a = 15'($urandom);
            a[7:4] = 4'h3;  // keep a small alias set so reads hit written data
            do_op(1'($urandom), a, 8'($urandom));
        end

        @(negedge clk);
        chk(rsp_valid == 1'b0 && mem_ce_n, "R2 idle after last op", int'(rsp_valid), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule